// File: doc/BRIEF.md
# Sensor power and reset sequencer

This block sequences the reset and power state of an attached motion sensor that is reached over a serial register port. It drives the sensor's active-low reset pin with a pulse of guaranteed minimum width. It reaches the sensor's power-down, wake and rest controls by handing single register writes to a separate register-access engine. It holds a motion-valid flag low until the settle time that belongs to the last reset, wake or rest exit has fully elapsed. Every delay is a cycle count worked out at elaboration from the `CLK_HZ` parameter, rounded up and never below one cycle.

The host drives single-cycle request pulses for reset, power-down, wake, rest entry and rest exit. A level input selects how a wake is done: by a reset pulse or by the magic write. Register writes leave on a valid/ready port. Once `wr_valid` is high, it and the address and data stay unchanged until the engine raises `wr_ready`. The transfer happens on the first edge with both high. The engine may hold `wr_ready` low for any number of cycles. The one exception is a host reset request, which withdraws a pending write. A delay counter never starts before its write has been accepted.

Top module: `sens_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `sensor_rst_n`, `motion_valid`, `wr_valid`, `pd_reached` and `rest_reached` are all low.
- R2: Every reset pulse holds `sensor_rst_n` low for exactly RST_C = ceil(250 ns x CLK_HZ) cycles (minimum 1). This applies after `rst_n` is released and after each accepted `host_rst_req`.
- R3: After a reset pulse that did not start from the powered-down state, `motion_valid` rises exactly MOT_C = ceil(50 ms x CLK_HZ) cycles after `sensor_rst_n` rises.
- R4: `pd_req` in the active state drops `motion_valid` on the next edge and presents a write of data 0x02 (bit 1 set) to address 0x0D. `pd_reached` rises PD_C = ceil(50 ms x CLK_HZ) cycles after the edge that accepts the write.
- R5: `wake_req` while powered down with `wake_by_write` = 1 presents a write of 0x5A to address 0x3A. `motion_valid` rises WAKE_C = ceil(55 ms x CLK_HZ) cycles after the accepting edge.
- R6: `wake_req` while powered down with `wake_by_write` = 0 issues a reset pulse. `motion_valid` then rises WAKE_C cycles after `sensor_rst_n` rises.
- R7: `rest_on_req` in the active state presents a write of 0x40 to address 0x0D. `rest_reached` rises REST_C = ceil(1 s x CLK_HZ) cycles after the accepting edge. If `pd_req` arrives in the same cycle, it wins.
- R8: `rest_off_req` in the rest state presents a write of 0x00 to address 0x0D. The exit settle ends REST_C cycles after the accepting edge.
- R9: A `pd_req` or `rest_on_req` that arrives during a reset pulse or a settle is held until the settle ends. The held request is then acted on without `motion_valid` rising, and power-down wins over rest. A host reset discards held requests.
- R10: Once raised, `wr_valid` stays high with `wr_addr` and `wr_data` stable until an edge where `wr_ready` is high. Only `host_rst_req` can withdraw it.
- R11: `host_rst_req` in any state starts a new reset pulse on the next edge and withdraws any pending write. If it arrives while powered down, the wake settle (R6) follows.
- R12: Requests arriving outside their states are ignored: `wake_req` outside powered-down, `rest_off_req` outside rest, and `pd_req` or `rest_on_req` while powered down, in rest, or while entering either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_rst_req | input | 1 | Pulse: reset the sensor |
| pd_req | input | 1 | Pulse: enter power-down |
| rest_on_req | input | 1 | Pulse: enter forced rest |
| rest_off_req | input | 1 | Pulse: leave forced rest |
| wake_req | input | 1 | Pulse: wake from power-down |
| wake_by_write | input | 1 | Wake method: 1 = magic write, 0 = reset pulse |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Register engine accepts the write |
| wr_addr | output | AW (7) | Register address of the write |
| wr_data | output | DW (8) | Register data of the write |
| sensor_rst_n | output | 1 | Active-low reset pin to the sensor |
| motion_valid | output | 1 | Motion data may be trusted |
| pd_reached | output | 1 | Sensor is treated as in low-current power-down |
| rest_reached | output | 1 | Sensor is treated as in forced rest |

## Verification
Each request pulse is taken on the edge that samples it, and the outputs show the new state one cycle later. Each settle or entry result is due exactly its delay count after the edge that started the delay. For a write, that edge is the one where `wr_valid` and `wr_ready` are both high. For a settle after a pulse, it is the edge where `sensor_rst_n` rises. The bench drives inputs just after the rising edge and samples on the falling edge. It time-stamps reset rises and falls, accepted writes and flag rises in falling-edge counts, then compares each gap with the rounded-up cycle count: gap N for a settle measured from the reset rise, N+1 when measured from the handshake. A behavioural model stepped on each rising edge predicts every output, and the outputs are compared with it at every falling edge.

// File: rtl/sens_pwr_pkg.sv
package sens_pwr_pkg;

  typedef enum logic [3:0] {
    ST_RESET_PULSE,
    ST_SETTLE,
    ST_ACTIVE,
    ST_PD_ENTER,
    ST_POWER_DOWN,
    ST_WAKE_SETTLE,
    ST_REST_ENTER,
    ST_REST,
    ST_REST_EXIT
  } sps_state_e;

  // Cycles covering a span of ns nanoseconds at hz, rounded up, at least 1.
  function automatic int ns_to_cyc(longint hz, longint ns);
    longint c;
    c = (hz * ns + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/sps_timer.sv
module sps_timer #(
  parameter int W    = 8,
  parameter int INIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expire
);

  logic [W-1:0] cnt_q;
  logic         run_q;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(INIT - 1);
      run_q <= 1'b1;
    end else if (load) begin
      cnt_q <= len - W'(1);
      run_q <= 1'b1;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

endmodule

// File: rtl/sps_pend.sv
module sps_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] held
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              held[i] <= 1'b0;
      else if (clr)            held[i] <= 1'b0;
      else if (cap_en && set[i]) held[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/sens_pwr_seq.sv
module sens_pwr_seq
  import sens_pwr_pkg::*;
#(
  parameter longint          CLK_HZ        = 50_000_000,
  parameter int              AW            = 7,
  parameter int              DW            = 8,
  parameter logic [AW-1:0]   CFG_ADDR      = 7'h0D,
  parameter logic [DW-1:0]   PD_DATA       = 8'h02,
  parameter logic [AW-1:0]   WAKE_ADDR     = 7'h3A,
  parameter logic [DW-1:0]   WAKE_DATA     = 8'h5A,
  parameter logic [AW-1:0]   REST_ADDR     = 7'h0D,
  parameter logic [DW-1:0]   REST_ON_DATA  = 8'h40,
  parameter logic [DW-1:0]   REST_OFF_DATA = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rst_req,
  input  logic          pd_req,
  input  logic          rest_on_req,
  input  logic          rest_off_req,
  input  logic          wake_req,
  input  logic          wake_by_write,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sensor_rst_n,
  output logic          motion_valid,
  output logic          pd_reached,
  output logic          rest_reached
);

  localparam int RST_C  = ns_to_cyc(CLK_HZ, 250);
  localparam int MOT_C  = ns_to_cyc(CLK_HZ, 50_000_000);
  localparam int PD_C   = ns_to_cyc(CLK_HZ, 50_000_000);
  localparam int WAKE_C = ns_to_cyc(CLK_HZ, 55_000_000);
  localparam int REST_C = ns_to_cyc(CLK_HZ, 1_000_000_000);
  localparam int TW     = $clog2(REST_C + 1);

  sps_state_e   st_q, st_d;
  logic         busy_q, busy_d;
  logic         wake_q, wake_d;
  logic         tmr_load, tmr_exp, pend_clr, pend_cap;
  logic [TW-1:0] tmr_len;
  logic [1:0]   pend_q;
  logic         eff_pd, eff_rest;

  sps_timer #(.W(TW), .INIT(RST_C)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expire(tmr_exp)
  );

  assign pend_cap = (st_q == ST_RESET_PULSE) || (st_q == ST_SETTLE) ||
                    (st_q == ST_WAKE_SETTLE) || (st_q == ST_REST_EXIT);

  sps_pend #(.N(2)) u_pend (
    .clk(clk), .rst_n(rst_n), .cap_en(pend_cap), .clr(pend_clr),
    .set({rest_on_req, pd_req}), .held(pend_q)
  );

  assign eff_pd   = pd_req | pend_q[0];
  assign eff_rest = rest_on_req | pend_q[1];

  always_comb begin
    st_d     = st_q;
    busy_d   = busy_q;
    wake_d   = wake_q;
    tmr_load = 1'b0;
    tmr_len  = TW'(RST_C);
    pend_clr = 1'b0;
    if (host_rst_req) begin
      st_d     = ST_RESET_PULSE;
      busy_d   = 1'b0;
      wake_d   = (st_q == ST_POWER_DOWN);
      tmr_load = 1'b1;
      pend_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_RESET_PULSE: if (tmr_exp) begin
          tmr_load = 1'b1;
          if (wake_q) begin st_d = ST_WAKE_SETTLE; tmr_len = TW'(WAKE_C); end
          else        begin st_d = ST_SETTLE;      tmr_len = TW'(MOT_C);  end
        end
        ST_SETTLE, ST_WAKE_SETTLE, ST_REST_EXIT: begin
          if (busy_q) begin
            if (wr_ready) begin
              busy_d   = 1'b0;
              tmr_load = 1'b1;
              tmr_len  = (st_q == ST_REST_EXIT) ? TW'(REST_C) : TW'(WAKE_C);
            end
          end else if (tmr_exp) begin
            pend_clr = 1'b1;
            if (eff_pd)        begin st_d = ST_PD_ENTER;   busy_d = 1'b1; end
            else if (eff_rest) begin st_d = ST_REST_ENTER; busy_d = 1'b1; end
            else                     st_d = ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (pd_req)           begin st_d = ST_PD_ENTER;   busy_d = 1'b1; end
          else if (rest_on_req) begin st_d = ST_REST_ENTER; busy_d = 1'b1; end
        end
        ST_PD_ENTER, ST_REST_ENTER: begin
          if (busy_q) begin
            if (wr_ready) begin
              busy_d   = 1'b0;
              tmr_load = 1'b1;
              tmr_len  = (st_q == ST_PD_ENTER) ? TW'(PD_C) : TW'(REST_C);
            end
          end else if (tmr_exp) begin
            st_d = (st_q == ST_PD_ENTER) ? ST_POWER_DOWN : ST_REST;
          end
        end
        ST_POWER_DOWN: if (wake_req) begin
          if (wake_by_write) begin
            st_d   = ST_WAKE_SETTLE;
            busy_d = 1'b1;
          end else begin
            st_d     = ST_RESET_PULSE;
            wake_d   = 1'b1;
            tmr_load = 1'b1;
          end
        end
        ST_REST: if (rest_off_req) begin
          st_d   = ST_REST_EXIT;
          busy_d = 1'b1;
        end
        default: st_d = ST_RESET_PULSE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RESET_PULSE;
      busy_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      wake_q <= wake_d;
    end
  end

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    if (busy_q) begin
      unique case (st_q)
        ST_PD_ENTER:    begin wr_addr = CFG_ADDR;  wr_data = PD_DATA;       end
        ST_WAKE_SETTLE: begin wr_addr = WAKE_ADDR; wr_data = WAKE_DATA;     end
        ST_REST_ENTER:  begin wr_addr = REST_ADDR; wr_data = REST_ON_DATA;  end
        ST_REST_EXIT:   begin wr_addr = REST_ADDR; wr_data = REST_OFF_DATA; end
        default:        begin wr_addr = '0;        wr_data = '0;            end
      endcase
    end
  end

  assign wr_valid     = busy_q;
  assign sensor_rst_n = (st_q != ST_RESET_PULSE);
  assign motion_valid = (st_q == ST_ACTIVE);
  assign pd_reached   = (st_q == ST_POWER_DOWN);
  assign rest_reached = (st_q == ST_REST);

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !host_rst_req |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R11
  host_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst_req |=> !sensor_rst_n && !wr_valid);

  // R3
  mv_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motion_valid) |-> $past(tmr_exp));

  // R9
  mv_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motion_valid) |-> !$past(pend_q[0]) && !$past(pend_q[1]));

  // R4
  pd_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_reached) |-> $past(tmr_exp) && !wr_valid);

  // R12
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_reached && !host_rst_req && !wake_req |=> pd_reached);

endmodule

// File: tb/sens_pwr_seq_bench.sv
module sens_pwr_seq_bench;

  localparam longint HZ = 10_000;

  function automatic int cyc(longint ns);
    longint c;
    c = (HZ * ns + 64'sd999_999_999) / 64'sd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int RST_C  = cyc(250);
  localparam int MOT_C  = cyc(50_000_000);
  localparam int PD_C   = cyc(50_000_000);
  localparam int WAKE_C = cyc(55_000_000);
  localparam int REST_C = cyc(1_000_000_000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rst_req = 0, pd_req = 0, rest_on_req = 0, rest_off_req = 0;
  logic wake_req = 0, wake_by_write = 0, wr_ready = 1;
  logic wr_valid, sensor_rst_n, motion_valid, pd_reached, rest_reached;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  sens_pwr_seq #(.CLK_HZ(HZ)) u_sens_pwr_seq (
    .clk(clk), .rst_n(rst_n), .host_rst_req(host_rst_req), .pd_req(pd_req),
    .rest_on_req(rest_on_req), .rest_off_req(rest_off_req), .wake_req(wake_req),
    .wake_by_write(wake_by_write), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sensor_rst_n(sensor_rst_n),
    .motion_valid(motion_valid), .pd_reached(pd_reached), .rest_reached(rest_reached)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: phase, cycles left in phase, pending and write flags.
  localparam int P_PULSE = 0, P_SET = 1, P_ACT = 2, P_PDE = 3, P_PD = 4,
                 P_WSET = 5, P_RSE = 6, P_REST = 7, P_REXIT = 8;
  int m_ph, m_left;
  bit m_wk, m_ppd, m_prs, m_wb, m_epd, m_ers;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = P_PULSE; m_left = RST_C; m_wk = 0; m_ppd = 0; m_prs = 0; m_wb = 0;
    end else if (host_rst_req) begin
      m_wk = (m_ph == P_PD); m_ph = P_PULSE; m_left = RST_C;
      m_ppd = 0; m_prs = 0; m_wb = 0;
    end else begin
      case (m_ph)
        P_PULSE: begin
          if (pd_req) m_ppd = 1;
          if (rest_on_req) m_prs = 1;
          if (m_left == 1) begin
            m_ph = m_wk ? P_WSET : P_SET; m_left = m_wk ? WAKE_C : MOT_C;
          end else m_left--;
        end
        P_SET, P_WSET, P_REXIT: begin
          if (m_wb) begin
            if (pd_req) m_ppd = 1;
            if (rest_on_req) m_prs = 1;
            if (wr_ready) begin m_wb = 0; m_left = (m_ph == P_REXIT) ? REST_C : WAKE_C; end
          end else if (m_left == 1) begin
            m_epd = m_ppd | pd_req; m_ers = m_prs | rest_on_req;
            m_ppd = 0; m_prs = 0;
            if (m_epd)      begin m_ph = P_PDE; m_wb = 1; end
            else if (m_ers) begin m_ph = P_RSE; m_wb = 1; end
            else m_ph = P_ACT;
          end else begin
            if (pd_req) m_ppd = 1;
            if (rest_on_req) m_prs = 1;
            m_left--;
          end
        end
        P_ACT: begin
          if (pd_req) begin m_ph = P_PDE; m_wb = 1; end
          else if (rest_on_req) begin m_ph = P_RSE; m_wb = 1; end
        end
        P_PDE, P_RSE: begin
          if (m_wb) begin
            if (wr_ready) begin m_wb = 0; m_left = (m_ph == P_PDE) ? PD_C : REST_C; end
          end else if (m_left == 1) m_ph = (m_ph == P_PDE) ? P_PD : P_REST;
          else m_left--;
        end
        P_PD: if (wake_req) begin
          if (wake_by_write) begin m_ph = P_WSET; m_wb = 1; end
          else begin m_ph = P_PULSE; m_left = RST_C; m_wk = 1; end
        end
        P_REST: if (rest_off_req) begin m_ph = P_REXIT; m_wb = 1; end
        default: ;
      endcase
    end
  end

  function automatic int exp_addr(int ph);
    return (ph == P_WSET) ? 'h3A : 'h0D;
  endfunction
  function automatic int exp_data(int ph);
    case (ph)
      P_PDE:   return 'h02;
      P_WSET:  return 'h5A;
      P_RSE:   return 'h40;
      default: return 'h00;
    endcase
  endfunction

  // Falling-edge time stamps and per-cycle model comparison.
  int tnow = 0, t_rr = 0, t_rf = 0, t_mv = 0, t_pd = 0, t_rest = 0, t_acc = 0, mv_rises = 0;
  int acc_a = 0, acc_d = 0;
  bit p_rst = 0, p_mv = 0, p_pd = 0, p_rs = 0;

  always @(negedge clk) begin
    tnow++;
    if (!p_rst && sensor_rst_n) t_rr = tnow;
    if (p_rst && !sensor_rst_n) t_rf = tnow;
    if (!p_mv && motion_valid) begin t_mv = tnow; mv_rises++; end
    if (!p_pd && pd_reached) t_pd = tnow;
    if (!p_rs && rest_reached) t_rest = tnow;
    if (wr_valid && wr_ready) begin t_acc = tnow; acc_a = wr_addr; acc_d = wr_data; end
    p_rst = sensor_rst_n; p_mv = motion_valid; p_pd = pd_reached; p_rs = rest_reached;
    if (rst_n) begin
      total++;
      if (sensor_rst_n !== (m_ph != P_PULSE) || motion_valid !== (m_ph == P_ACT) ||
          wr_valid !== m_wb || pd_reached !== (m_ph == P_PD) || rest_reached !== (m_ph == P_REST) ||
          (m_wb && (int'(wr_addr) != exp_addr(m_ph) || int'(wr_data) != exp_data(m_ph)))) begin
        bad++;
        if (sensor_rst_n !== (m_ph != P_PULSE))
          $display("FAIL R2 cycle %0d sensor_rst_n act=%0b exp=%0b", tnow, sensor_rst_n, m_ph != P_PULSE);
        if (motion_valid !== (m_ph == P_ACT))
          $display("FAIL R3 cycle %0d motion_valid act=%0b exp=%0b", tnow, motion_valid, m_ph == P_ACT);
        if (wr_valid !== m_wb)
          $display("FAIL R10 cycle %0d wr_valid act=%0b exp=%0b", tnow, wr_valid, m_wb);
        if (m_wb && int'(wr_data) != exp_data(m_ph))
          $display("FAIL R10 cycle %0d wr_data act=%0h exp=%0h", tnow, wr_data, exp_data(m_ph));
        if (m_wb && int'(wr_addr) != exp_addr(m_ph))
          $display("FAIL R10 cycle %0d wr_addr act=%0h exp=%0h", tnow, wr_addr, exp_addr(m_ph));
        if (pd_reached !== (m_ph == P_PD))
          $display("FAIL R4 cycle %0d pd_reached act=%0b exp=%0b", tnow, pd_reached, m_ph == P_PD);
        if (rest_reached !== (m_ph == P_REST))
          $display("FAIL R7 cycle %0d rest_reached act=%0b exp=%0b", tnow, rest_reached, m_ph == P_REST);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask
  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  bit finished = 0;

  initial begin
    int mv_before;
    run(3);
    @(negedge clk);
    // R1 reset state
    chk(!sensor_rst_n && !motion_valid && !wr_valid && !pd_reached && !rest_reached,
        "R1", "outputs in reset", {sensor_rst_n, motion_valid, wr_valid, pd_reached, rest_reached}, 0);
    tick(); rst_n = 1;
    run(MOT_C + RST_C + 5);
    chk(t_mv - t_rr == MOT_C, "R3", "power-up settle", t_mv - t_rr, MOT_C);

    // R4 with back-pressure (R10)
    wr_ready = 0;
    pd_req = 1; tick(); pd_req = 0;
    run(4);
    chk(wr_valid && wr_addr == 7'h0D && wr_data == 8'h02, "R10", "held pd write",
        {wr_valid, wr_addr, wr_data}, {1'b1, 7'h0D, 8'h02});
    chk(!motion_valid, "R4", "motion dropped", motion_valid, 0);
    wr_ready = 1;
    run(PD_C + 5);
    chk(t_pd - t_acc == PD_C + 1, "R4", "pd entry delay", t_pd - t_acc, PD_C + 1);

    // R12 ignored in power-down
    pd_req = 1; rest_on_req = 1; tick(); pd_req = 0; rest_on_req = 0;
    run(3);
    chk(pd_reached && !wr_valid, "R12", "pd/rest ignored in power-down", pd_reached, 1);

    // R5 wake by write
    wake_by_write = 1;
    wake_req = 1; tick(); wake_req = 0;
    run(WAKE_C + 5);
    chk(acc_a == 'h3A && acc_d == 'h5A, "R5", "wake write", acc_d, 'h5A);
    chk(t_mv - t_acc == WAKE_C + 1, "R5", "wake settle", t_mv - t_acc, WAKE_C + 1);

    // R12 ignored in active
    wake_req = 1; rest_off_req = 1; tick(); wake_req = 0; rest_off_req = 0;
    run(3);
    chk(motion_valid && !wr_valid, "R12", "wake/rest_off ignored in active", motion_valid, 1);

    // R6 wake by pulse
    pd_req = 1; tick(); pd_req = 0;
    run(PD_C + 5);
    wake_by_write = 0;
    wake_req = 1; tick(); wake_req = 0;
    run(WAKE_C + RST_C + 5);
    chk(t_rr - t_rf == RST_C, "R2", "pulse width", t_rr - t_rf, RST_C);
    chk(t_mv - t_rr == WAKE_C, "R6", "wake-by-pulse settle", t_mv - t_rr, WAKE_C);

    // R7 rest entry, pd priority checked afterwards
    rest_on_req = 1; tick(); rest_on_req = 0;
    run(REST_C + 5);
    chk(acc_a == 'h0D && acc_d == 'h40, "R7", "rest-on write", acc_d, 'h40);
    chk(t_rest - t_acc == REST_C + 1, "R7", "rest entry delay", t_rest - t_acc, REST_C + 1);
    pd_req = 1; tick(); pd_req = 0;
    run(3);
    chk(rest_reached && !wr_valid, "R12", "pd ignored in rest", rest_reached, 1);

    // R8 rest exit with held requests (R9)
    rest_off_req = 1; tick(); rest_off_req = 0;
    run(5);
    chk(acc_a == 'h0D && acc_d == 'h00, "R8", "rest-off write", acc_d, 'h00);
    begin
      int t_exit_acc;
      t_exit_acc = t_acc;
      mv_before = mv_rises;
      pd_req = 1; rest_on_req = 1; tick(); pd_req = 0; rest_on_req = 0;
      run(REST_C + PD_C + 10);
      chk(t_acc - t_exit_acc == REST_C + 1, "R8", "rest exit settle", t_acc - t_exit_acc, REST_C + 1);
      chk(mv_rises == mv_before, "R9", "no motion between settle and held pd", mv_rises - mv_before, 0);
      chk(pd_reached && acc_d == 'h02, "R9", "held pd wins over rest", pd_reached, 1);
    end

    // R11 host reset from power-down takes the wake settle
    host_rst_req = 1; tick(); host_rst_req = 0;
    run(WAKE_C + RST_C + 5);
    chk(t_rr - t_rf == RST_C, "R11", "host reset pulse width", t_rr - t_rf, RST_C);
    chk(t_mv - t_rr == WAKE_C, "R11", "host reset from power-down settle", t_mv - t_rr, WAKE_C);

    // R11 host reset withdraws a stalled write
    wr_ready = 0;
    pd_req = 1; tick(); pd_req = 0;
    run(3);
    host_rst_req = 1; tick(); host_rst_req = 0;
    run(2);
    chk(!wr_valid && !sensor_rst_n == (RST_C > 1), "R11", "write withdrawn", wr_valid, 0);
    wr_ready = 1;
    run(5);
    // R9 host reset discards a held request
    pd_req = 1; tick(); pd_req = 0;
    host_rst_req = 1; tick(); host_rst_req = 0;
    run(MOT_C + RST_C + 5);
    chk(motion_valid && !pd_reached, "R9", "held pd discarded by host reset", motion_valid, 1);
    chk(t_mv - t_rr == MOT_C, "R3", "settle after plain host reset", t_mv - t_rr, MOT_C);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule